// File: doc/BRIEF.md
# Branch Program Flow Trace Packer

This block compresses the program-flow part of an instruction trace. Every conditional branch the core resolves arrives as a one-cycle strobe with a taken bit. The packer gathers these outcomes into 18-bit items, each holding up to twelve outcome bits, a 4-bit outcome count and a 2-bit item kind. When the surrounding logic decides that an absolute program counter must be recorded, it raises a PC request with the 32-bit value. The packer then writes any branches it still holds, followed by a two-item PC record. A flush request closes the open branch item early. If no branches are open, the flush produces an empty item that consumers skip, which lets a downstream packet be completed.

Items leave through a valid/ready stream. An item is transferred on every rising edge where `item_valid` and `item_ready` are both high. While `item_ready` is low, the item on `item_data` stays unchanged and `item_valid` stays high. Back-pressure never stops the inputs, which have no ready signal. Branch strobes that arrive during a stall are still packed, and the finished items wait in an internal queue of `FIFO_DEPTH` entries. If all the items a single cycle produces cannot fit in the queue, every item of that cycle is discarded. The open branch state is cleared as though those items had been written, and the sticky `overflow` pin goes high.

Top module: `bpf_trace_packer`

## Requirements
- R1: Bits 17:16 of every item give its kind: 2'b00 for a branch item and 2'b01 for a program-counter item. No other value appears.
- R2: In a branch item, bits 15:12 hold the outcome count N (0 to 12). The first outcome sits in bit 11 and later ones follow toward bit 0 in arrival order. A bit value of 1 means taken and 0 means not taken.
- R3: In a branch item, the 12-N low bits of field 11:0 that carry no outcome are zero.
- R4: The strobe that brings the open count to 12 emits a full item (count 12). The next strobe starts a new item at bit 11.
- R5: A flush emits the open branch item with its current count. A flush while no branches are open emits one item with count 0 and field 11:0 zero.
- R6: A PC request emits two items of kind 01. The first carries pc_value[31:16] in bits 15:0 and the second carries pc_value[15:0].
- R7: When a PC request arrives with open branches, their branch item is emitted before the PC record. A flush in the same cycle as a PC request adds no item of its own. A branch strobe in the same cycle is packed before either request is acted on.
- R8: While `item_valid` is high and `item_ready` is low, `item_valid` stays high and `item_data` stays stable. Items leave in the order they were produced.
- R9: Branch strobes keep being packed while the output is stalled. Up to FIFO_DEPTH finished items are held.
- R10: If the items produced in one cycle do not all fit in the queue, all of them are dropped and the open branch state is still cleared. `overflow` then goes high and stays high until reset.
- R11: After reset, `item_valid` and `overflow` are low and the open branch count is zero.
- R12: With an empty queue, an item produced by inputs sampled at a rising edge is valid right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | One resolved conditional branch this cycle |
| br_taken | input | 1 | Outcome of that branch, 1 = taken |
| pc_valid | input | 1 | Request to record a program counter |
| pc_value | input | 32 | Program counter to record |
| flush | input | 1 | Close the open branch item now |
| item_valid | output | 1 | `item_data` holds an item |
| item_ready | input | 1 | Consumer accepts the item this cycle |
| item_data | output | 18 | Trace item |
| overflow | output | 1 | Sticky: at least one cycle's items were dropped |

## Verification
Each input is sampled at one rising edge. The items it produces are written into the queue at that same edge, so with an empty queue the first of them is on the port immediately after the edge (R12). Further items follow one per accepted transfer. The driver changes inputs one time unit after a rising edge. The monitor compares at the falling edge, so it sees exactly the values the next rising edge uses for the handshake. A scoreboard queue is filled in program order as stimulus is driven, so any latency that matches the requirements only shifts when items are popped, never what they contain. Explicit timed checks cover the cycle-exact cases: the first falling edge after a flush, a held item over several stalled cycles, and the overflow pin before and after the dropped cycle.

// File: rtl/trace_pack_pkg.sv
package trace_pack_pkg;
  localparam int ITEM_W = 18;
  localparam int SLOTS  = 12;
  localparam int CNT_W  = 4;
  localparam int HALF_W = 16;
  localparam int PC_W   = 2 * HALF_W;
  localparam int LANES  = 3;
  localparam int LANE_W = $clog2(LANES + 1);

  typedef logic [ITEM_W-1:0] item_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [SLOTS-1:0]  slots_t;

  typedef enum logic [1:0] {
    KIND_BRANCH = 2'b00,
    KIND_PC     = 2'b01
  } kind_e;

  function automatic item_t mk_branch(cnt_t n, slots_t b);
    kind_e k;
    k = KIND_BRANCH;
    return {k, n, b};
  endfunction

  function automatic item_t mk_pc(logic [HALF_W-1:0] h);
    kind_e k;
    k = KIND_PC;
    return {k, h};
  endfunction
endpackage

// File: rtl/trace_br_accum.sv
module trace_br_accum
  import trace_pack_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev,
  input  logic   taken,
  input  logic   drain,
  output cnt_t   post_cnt,
  output slots_t post_bits,
  output logic   post_full
);
  cnt_t   cnt_q;
  slots_t bits_q;

  // view of the open item after this cycle's strobe is applied
  always_comb begin
    post_cnt  = cnt_q;
    post_bits = bits_q;
    if (ev) begin
      post_bits[CNT_W'(SLOTS - 1) - cnt_q] = taken;
      post_cnt = cnt_q + cnt_t'(1);
    end
    post_full = (post_cnt == cnt_t'(SLOTS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (drain || post_full) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else begin
      cnt_q  <= post_cnt;
      bits_q <= post_bits;
    end
  end
endmodule

// File: rtl/trace_emit_sel.sv
module trace_emit_sel
  import trace_pack_pkg::*;
(
  input  cnt_t                    post_cnt,
  input  slots_t                  post_bits,
  input  logic                    post_full,
  input  logic                    pc_req,
  input  logic [PC_W-1:0]         pc,
  input  logic                    flush,
  output logic [LANES-1:0][ITEM_W-1:0] lane,
  output logic [LANE_W-1:0]       n_items,
  output logic                    drain
);
  logic [LANE_W-1:0] k;

  always_comb begin
    lane = '0;
    k    = '0;
    if (post_full) begin
      lane[k] = mk_branch(post_cnt, post_bits);
      k = k + LANE_W'(1);
    end
    if (pc_req) begin
      if (!post_full && post_cnt != '0) begin
        lane[k] = mk_branch(post_cnt, post_bits);
        k = k + LANE_W'(1);
      end
      lane[k] = mk_pc(pc[PC_W-1:HALF_W]);
      k = k + LANE_W'(1);
      lane[k] = mk_pc(pc[HALF_W-1:0]);
      k = k + LANE_W'(1);
    end else if (flush) begin
      lane[k] = post_full ? mk_branch('0, '0) : mk_branch(post_cnt, post_bits);
      k = k + LANE_W'(1);
    end
    n_items = k;
    drain   = pc_req | flush;
  end
endmodule

// File: rtl/trace_item_fifo.sv
module trace_item_fifo
  import trace_pack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANE_W-1:0]            wr_n,
  input  logic [LANES-1:0][ITEM_W-1:0] wr_data,
  input  logic                         pop,
  output logic [ITEM_W-1:0]            rd_data,
  output logic                         not_empty,
  output logic [CW-1:0]                count
);
  item_t        mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] lane_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_addr
    assign lane_addr[g] = wr_ptr + PW'(g);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (LANE_W'(i) < wr_n) mem[lane_addr[i]] <= wr_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(wr_n);
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      count <= count + CW'(wr_n) - CW'(pop);
    end
  end

  assign rd_data   = mem[rd_ptr];
  assign not_empty = (count != '0);
endmodule

// File: rtl/bpf_trace_packer.sv
module bpf_trace_packer
  import trace_pack_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_valid,
  input  logic        br_taken,
  input  logic        pc_valid,
  input  logic [31:0] pc_value,
  input  logic        flush,
  output logic        item_valid,
  input  logic        item_ready,
  output logic [17:0] item_data,
  output logic        overflow
);
  cnt_t                         post_cnt;
  slots_t                       post_bits;
  logic                         post_full;
  logic [LANES-1:0][ITEM_W-1:0] lane;
  logic [LANE_W-1:0]            n_items;
  logic [LANE_W-1:0]            wr_n;
  logic                         drain;
  logic [CW-1:0]                count;
  logic [CW-1:0]                free_slots;
  logic                         fits;
  logic                         ovf_q;

  trace_br_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (br_valid),
    .taken    (br_taken),
    .drain    (drain),
    .post_cnt (post_cnt),
    .post_bits(post_bits),
    .post_full(post_full)
  );

  trace_emit_sel u_sel (
    .post_cnt (post_cnt),
    .post_bits(post_bits),
    .post_full(post_full),
    .pc_req   (pc_valid),
    .pc       (pc_value),
    .flush    (flush),
    .lane     (lane),
    .n_items  (n_items),
    .drain    (drain)
  );

  // all-or-nothing admission of one cycle's items
  assign free_slots = CW'(FIFO_DEPTH) - count;
  assign fits       = (CW'(n_items) <= free_slots);
  assign wr_n       = fits ? n_items : '0;

  trace_item_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .wr_data  (lane),
    .pop      (item_valid & item_ready),
    .rd_data  (item_data),
    .not_empty(item_valid),
    .count    (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf_q <= 1'b0;
    else if (!fits && n_items != '0) ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/bpf_trace_packer_chk.sv
module bpf_trace_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        item_valid,
  input logic        item_ready,
  input logic [17:0] item_data,
  input logic        overflow
);
  logic [11:0] spare_mask;
  assign spare_mask = 12'hFFF >> item_data[15:12];

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid |-> !item_data[17]); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid && item_data[17:16] == 2'b00) |-> item_data[15:12] <= 4'd12); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid && item_data[17:16] == 2'b00) |-> (item_data[11:0] & spare_mask) == 12'h000); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid && !item_ready) |=> (item_valid && $stable(item_data))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R10
endmodule

bind bpf_trace_packer bpf_trace_packer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .item_valid(item_valid),
  .item_ready(item_ready),
  .item_data (item_data),
  .overflow  (overflow)
);

// File: tb/test_bpf_trace_packer.sv
module test_bpf_trace_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0, br_taken = 1'b0, pc_valid = 1'b0, flush = 1'b0;
  logic [31:0] pc_value = '0;
  logic        item_ready = 1'b0;
  logic        item_valid, overflow;
  logic [17:0] item_data;

  int errors = 0, checks = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  int          m_cnt = 0;
  logic [11:0] m_bits = '0;
  bit          done = 0;

  always #5 clk = ~clk;

  bpf_trace_packer #(.FIFO_DEPTH(8)) i_bpf_trace_packer (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .pc_valid(pc_valid), .pc_value(pc_value), .flush(flush),
    .item_valid(item_valid), .item_ready(item_ready), .item_data(item_data),
    .overflow(overflow));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_item(logic [17:0] v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic close_branch(bit keep, string req);
    if (keep) expect_item({2'b00, 4'(m_cnt), m_bits}, req);
    m_cnt = 0; m_bits = '0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    br_valid = 0; pc_valid = 0; flush = 0;
  endtask

  task automatic branch(bit t);
    @(posedge clk); #1;
    br_valid = 1; br_taken = t; pc_valid = 0; flush = 0;
    m_bits[11 - m_cnt] = t; m_cnt++;
    if (m_cnt == 12) close_branch(1, "R4 full item"); // R4
  endtask

  task automatic do_flush(bit keep);
    @(posedge clk); #1;
    br_valid = 0; pc_valid = 0; flush = 1;
    close_branch(keep, "R5 flush item"); // R5
  endtask

  task automatic do_pc(logic [31:0] v, bit keep);
    @(posedge clk); #1;
    br_valid = 0; flush = 0; pc_valid = 1; pc_value = v;
    if (m_cnt > 0) close_branch(keep, "R7 branches before PC"); // R7
    if (keep) begin
      expect_item({2'b01, v[31:16]}, "R6 PC high half"); // R6
      expect_item({2'b01, v[15:0]}, "R6 PC low half");
    end
  endtask

  // monitor: compare each transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n && item_valid && item_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected item", 32'(item_data), 32'h0);
      end else begin
        check(item_data === exp_q[0], {tag_q[0], " (R1/R2)"}, 32'(item_data), 32'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic drain_wait();
    item_ready = 1;
    repeat (30) @(posedge clk);
    check(exp_q.size() == 0, "R8 all items delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(item_valid == 0, "R11 valid low after reset", item_valid, 0);
    check(overflow == 0, "R11 overflow low after reset", overflow, 0);

    // R12 / R11: flush with nothing open, stalled, valid right after the edge
    do_flush(1); idle();
    @(negedge clk);
    check(item_valid == 1, "R12 item valid one edge after flush", item_valid, 1);
    check(item_data == 18'h00000, "R5 R11 empty flush item", 32'(item_data), 0);
    drain_wait();

    // R2 R3 R5: five branches then flush
    item_ready = 1;
    branch(1); branch(0); branch(1); branch(1); branch(0);
    do_flush(1); idle();
    repeat (3) @(posedge clk);

    // R4: twelve branches, then three more start a fresh item
    for (int i = 0; i < 15; i++) branch(i % 3 == 0);
    do_flush(1); idle();
    repeat (3) @(posedge clk);

    // R7: open branches then PC; PC with none open; PC plus flush together
    branch(0); branch(1); branch(1);
    do_pc(32'hDEAD_BEEF, 1);
    do_pc(32'h1234_5678, 1);
    @(posedge clk); #1;
    flush = 1; pc_valid = 1; pc_value = 32'hA5A5_0F0F; br_valid = 0;
    expect_item({2'b01, 16'hA5A5}, "R7 flush absorbed by PC");
    expect_item({2'b01, 16'h0F0F}, "R6 PC low half");
    idle();
    // branch packed in same cycle as PC request
    @(posedge clk); #1;
    br_valid = 1; br_taken = 1; pc_valid = 1; pc_value = 32'h0000_0040;
    expect_item({2'b00, 4'd1, 12'h800}, "R7 same-cycle branch first");
    expect_item({2'b01, 16'h0000}, "R6 PC high half");
    expect_item({2'b01, 16'h0040}, "R6 PC low half");
    idle();
    drain_wait();

    // R8 R9: stall, keep packing 30 branches
    item_ready = 0;
    for (int i = 0; i < 30; i++) branch(i[0]);
    idle();
    @(negedge clk);
    held = item_data;
    repeat (4) @(negedge clk);
    check(item_valid == 1 && item_data == held, "R8 item held while stalled", 32'(item_data), 32'(held));
    do_flush(1); idle();
    drain_wait();

    // R10: overflow while stalled
    item_ready = 0;
    for (int i = 0; i < 4; i++) do_pc(32'h1000_0000 + 32'(i), 1);
    idle();
    @(negedge clk);
    check(overflow == 0, "R10 no overflow at exactly full", overflow, 0);
    do_pc(32'hFFFF_0000, 0); idle();
    @(negedge clk);
    check(overflow == 1, "R10 overflow raised", overflow, 1);
    branch(1); branch(1);
    m_cnt = 0; m_bits = '0;   // dropped with the PC below
    do_pc(32'h2222_3333, 0); idle();
    drain_wait();
    do_flush(1); idle();      // open state was cleared by the dropped cycle
    drain_wait();
    check(overflow == 1, "R10 overflow sticky", overflow, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule